// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block is a parallel I/O port. Each pin is either a general-purpose I/O or is handed to an on-chip peripheral. Software configures every pin through four per-pin registers on a small synchronous bus: a pin-assignment word, a direction word, an open-drain word and a data latch. The block drives the pad output value and the pad output enable. It routes peripheral drive values out to the pads, and synchronized pad values in to the peripherals. A peripheral input whose pin is not assigned to it receives a fixed fallback: a baud-rate generator tick on two pins, and logic 0 on all others.

Only bit positions 15..12 and 9..4 exist, and the other bit positions are inert. Pins 9, 8, 5 and 4 can drive as open-drain. Pins 9 and 8 have their dedicated direction reversed. Pad inputs cross two flip-flops before they are used. Pad outputs and read data are registered.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset all registers read 0, `pin_oe` is 0, `pin_out` is 0 and `fn_recv` is 0.
- R2: A write to the data latch (address 3) is stored whatever the pin's direction. A latch written while the pin is an input appears on `pin_out` once the pin is made an output.
- R3: A general-purpose pin (assignment bit 0) with direction bit 0 keeps its output enable at 0.
- R4: A general-purpose pin with direction bit 1 drives its latch value with output enable 1.
- R5: Reading address 3 returns the synchronized pad state, masked to implemented bits, and never the latch.
- R6: A pin with assignment bit 1 and effective direction 0 is a peripheral input: `fn_recv` follows the synchronized pad, and the output enable is 0.
- R7: A pin with assignment bit 1 and effective direction 1 is a peripheral output: `pin_out` follows `fn_drive`, and the output enable is 1.
- R8: When a peripheral input is not fed from its pin, `fn_recv` takes a fallback: bit 15 takes `brg_tick[0]`, bit 13 takes `brg_tick[1]`, and every other bit takes 0.
- R9: On pins 9, 8, 5 and 4 with the open-drain bit set, a driven 1 gives output enable 0, and a driven 0 gives output enable 1 with `pin_out` 0.
- R10: Open-drain bits of the other pins read back as 0 and do not change how those pins drive.
- R11: Bits 11, 10 and 3..0 read 0 from every register and ignore writes, and their output enable stays 0.
- R12: On pins 9 and 8 the effective dedicated direction is the inverse of the direction bit, so direction 1 makes the pin a peripheral input. General-purpose mode is not affected.
- R13: The registers at addresses 0 (assignment), 1 (direction) and 2 (open-drain) read back their written values. Read data appears one cycle after the address is presented. A read in the same cycle as a write to that register returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 assignment, 1 direction, 2 open-drain, 3 data |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous cycle |
| pin_in | input | 16 | Pad input values |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| fn_drive | input | 16 | Peripheral drive values, one per pin |
| fn_recv | output | 16 | Values delivered to peripheral inputs, one per pin |
| brg_tick | input | 2 | Baud-rate generator outputs used as fallbacks |

## Verification
A register write and a read of the same register can fall in one clock edge. The bench provokes this by presenting the direction address with the write strobe and new data. It judges that the read data of that cycle holds the old contents and that the next cycle holds the new ones. A second overlap is the open-drain rule and the reversed direction on pins 9 and 8. The bench enables open-drain on those pins while they act as dedicated outputs, and checks that a driven 1 releases the pad and that pins 5 and 4 keep normal polarity.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {RA_SEL = 2'd0, RA_DIR = 2'd1, RA_OD = 2'd2, RA_DAT = 2'd3} reg_addr_e;
  typedef enum logic [1:0] {DF_GND = 2'd0, DF_BRG0 = 2'd1, DF_BRG1 = 2'd2} dflt_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int          W       = 16,
  parameter logic [W-1:0] IMPL   = 16'hF3F0,
  parameter logic [W-1:0] OD_CAP = 16'h0330
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] sel_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] od_q,
  output logic [W-1:0] lat_q
);
  localparam logic [W-1:0] OD_KEEP = IMPL & OD_CAP;

  reg_addr_e ra;
  assign ra = reg_addr_e'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      dir_q <= '0;
      od_q  <= '0;
      lat_q <= '0;
    end else if (bus_we) begin
      case (ra)
        RA_SEL:  sel_q <= bus_wdata & IMPL;
        RA_DIR:  dir_q <= bus_wdata & IMPL;
        RA_OD:   od_q  <= bus_wdata & OD_KEEP;
        default: lat_q <= bus_wdata & IMPL;
      endcase
    end
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    case (ra)
      RA_SEL:  rd_mux = sel_q;
      RA_DIR:  rd_mux = dir_q;
      RA_OD:   rd_mux = od_q;
      default: rd_mux = pin_sync & IMPL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  p_rd_unimpl_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~IMPL) == '0);
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
#(
  parameter bit    OD_OK    = 1'b0,
  parameter bit    DIR_FLIP = 1'b0,
  parameter dflt_e DFLT     = DF_GND
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       dir,
  input  logic       od,
  input  logic       lat,
  input  logic       fn_o,
  input  logic       pin_s,
  input  logic [1:0] brg,
  output logic       pad_o,
  output logic       pad_oe,
  output logic       fn_i
);
  logic eff_dir, drive_en, drv_val, od_on, rx, dflt_v;

  always_comb begin
    eff_dir  = dir ^ (sel & DIR_FLIP);
    drive_en = eff_dir;
    drv_val  = sel ? fn_o : lat;
    od_on    = OD_OK & od & drive_en;
    rx       = sel & ~eff_dir;
    case (DFLT)
      DF_BRG0: dflt_v = brg[0];
      DF_BRG1: dflt_v = brg[1];
      default: dflt_v = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b0;
      fn_i   <= 1'b0;
    end else begin
      pad_o  <= drive_en & ~od_on & drv_val;
      pad_oe <= drive_en & ~(od_on & drv_val);
      fn_i   <= rx ? pin_s : dflt_v;
    end
  end

  p_gpio_in_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!sel && !dir) |=> !pad_oe);
  p_ded_in_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (sel && (dir == DIR_FLIP)) |=> !pad_oe);
  p_ded_out_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (sel && (dir != DIR_FLIP) && !(OD_OK && od)) |=> (pad_oe && pad_o == $past(fn_o)));
  p_od_never_high_r9: assert property (@(posedge clk) disable iff (rst)
    (OD_OK && od) |=> !pad_o);
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_pkg::*;
#(
  parameter int           W        = 16,
  parameter int           SYNC_STG = 2,
  parameter logic [W-1:0] IMPL     = 16'hF3F0,
  parameter logic [W-1:0] OD_CAP   = 16'h0330,
  parameter logic [W-1:0] DIR_INV  = 16'h0300,
  parameter logic [W-1:0] BRG0_PIN = 16'h8000,
  parameter logic [W-1:0] BRG1_PIN = 16'h2000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic [W-1:0] fn_drive,
  output logic [W-1:0] fn_recv,
  input  logic [1:0]   brg_tick
);
  logic [W-1:0] pin_sync, sel_q, dir_q, od_q, lat_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_regs #(.W(W), .IMPL(IMPL), .OD_CAP(OD_CAP)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
    .sel_q(sel_q), .dir_q(dir_q), .od_q(od_q), .lat_q(lat_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (IMPL[i]) begin : g_live
      localparam dflt_e DF = BRG0_PIN[i] ? DF_BRG0 : (BRG1_PIN[i] ? DF_BRG1 : DF_GND);
      gpio_pin_cell #(.OD_OK(OD_CAP[i]), .DIR_FLIP(DIR_INV[i]), .DFLT(DF)) u_cell (
        .clk(clk), .rst(rst), .sel(sel_q[i]), .dir(dir_q[i]), .od(od_q[i]),
        .lat(lat_q[i]), .fn_o(fn_drive[i]), .pin_s(pin_sync[i]), .brg(brg_tick),
        .pad_o(pin_out[i]), .pad_oe(pin_oe[i]), .fn_i(fn_recv[i])
      );
    end else begin : g_dead
      assign pin_out[i] = 1'b0;
      assign pin_oe[i]  = 1'b0;
      assign fn_recv[i] = 1'b0;
    end
  end
endmodule

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, pin_out, pin_oe, fn_recv;
  logic [15:0] pin_in = '0, fn_drive = '0;
  logic [1:0]  brg_tick = '0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fn_drive(fn_drive),
    .fn_recv(fn_recv), .brg_tick(brg_tick)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [15:0] exp);
    @(negedge clk); bus_addr = a;
    @(negedge clk); chk(req, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 oe", pin_oe, 16'h0);
    chk("R1 out", pin_out, 16'h0);
    chk("R1 recv", fn_recv, 16'h0);
    rd_chk("R1 sel", 2'd0, 16'h0);
    rd_chk("R1 dir", 2'd1, 16'h0);
    rd_chk("R1 od", 2'd2, 16'h0);
  endtask

  task automatic t_gpio();
    wr(2'd3, 16'hFFFF); settle();
    chk("R3 input no drive", pin_oe, 16'h0);
    wr(2'd1, 16'hF3F0); settle();
    chk("R2 latch kept", pin_out, 16'hF3F0);
    wr(2'd3, 16'hA5A5); settle();
    chk("R4 out", pin_out, 16'hA1A0);
    chk("R4 oe", pin_oe, 16'hF3F0);
    chk("R11 oe unimpl", pin_oe & 16'h0C0F, 16'h0);
    pin_in = 16'h1234; settle();
    rd_chk("R5 pin readback", 2'd3, 16'h1230);
  endtask

  task automatic t_regs();
    wr(2'd1, 16'h5A5A);
    rd_chk("R13 dir", 2'd1, 16'h5250);
    wr(2'd0, 16'hFFFF);
    rd_chk("R11 sel mask", 2'd0, 16'hF3F0);
    wr(2'd2, 16'hFFFF);
    rd_chk("R10 od mask", 2'd2, 16'h0330);
    wr(2'd2, 16'h0000); wr(2'd0, 16'h0000);
    @(negedge clk); bus_addr = 2'd1; bus_we = 1'b1; bus_wdata = 16'hFFFF;
    @(negedge clk); chk("R13 same-cycle old", bus_rdata, 16'h5250);
    bus_we = 1'b0;
    @(negedge clk); chk("R13 same-cycle new", bus_rdata, 16'hF3F0);
  endtask

  task automatic t_dedicated();
    pin_in = 16'hFFFF; fn_drive = 16'h0200; brg_tick = 2'b11;
    wr(2'd0, 16'hF3F0); wr(2'd1, 16'h0000); settle();
    chk("R6 recv", fn_recv, 16'hF0F0);
    chk("R12 oe flipped", pin_oe, 16'h0300);
    chk("R12 out", pin_out, 16'h0200);
    wr(2'd1, 16'hF3F0); fn_drive = 16'hA0A0; brg_tick = 2'b01; settle();
    chk("R7 out", pin_out, 16'hA0A0);
    chk("R7 oe", pin_oe, 16'hF0F0);
    chk("R8 brg0 fallback", fn_recv, 16'h8300);
    brg_tick = 2'b10; settle();
    chk("R8 brg1 fallback", fn_recv, 16'h2300);
    wr(2'd2, 16'h0330); wr(2'd1, 16'h0000); fn_drive = 16'h0100; settle();
    chk("R9 ded od oe", pin_oe, 16'h0200);
    chk("R9 ded od out", pin_out, 16'h0000);
  endtask

  task automatic t_opendrain();
    wr(2'd0, 16'h0000); wr(2'd1, 16'hF3F0); wr(2'd2, 16'h0330);
    wr(2'd3, 16'h0120); settle();
    chk("R9 oe", pin_oe, 16'hF2D0);
    chk("R9 out", pin_out, 16'h0000);
    wr(2'd2, 16'hFFFF); wr(2'd3, 16'h1120); settle();
    chk("R10 out", pin_out, 16'h1000);
    chk("R10 oe", pin_oe, 16'hF2D0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gpio();
    t_regs();
    t_dedicated();
    t_opendrain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule